// File: doc/BRIEF.md
# Self-Loop Idle Detector and Execute-Stage Gater

This block sits beside the retire port of a small in-order RISC-V core. Each retiring instruction is sorted into one of a few groups. The block picks out control-flow instructions that jump or branch to their own address, and base ALU-style instructions whose only target is the hard-wired zero register. A control transfer with a zero offset spins on one address. Once the block has proved that such a spin changes no architectural state, it raises an idle flag and asks for the execute-stage clock to be gated. It keeps that request until an interrupt becomes pending.

When the watchdog-enable input is set, the block does not gate the clock. A detected spin instead produces a single-cycle trap request, so the surrounding logic can break out of what may be a hung loop.

The ALU-style instructions that write only the zero register get a separate per-retirement hint. The hint marks them as effective no-ops, so downstream power logic can skip their datapath activity.

Top module: `spin_idle_gate`

## Requirements
- R1: A synchronous active-high reset clears `nop_hint`, `idle_loop`, `gate_req` and `trap_req`. It also forgets the stored PC and instruction word, so a linking self-jump that retired just before reset is not counted as a repeat after it.
- R2: A 32-bit jump with opcode bits 6:0 = 1101111, bits 31:12 all zero and destination bits 11:7 = 0 sets `idle_loop` and `gate_req` one cycle after its first retirement. This holds while the watchdog is off and no interrupt is pending.
- R3: The same zero-offset jump with a nonzero destination field sets `idle_loop` and `gate_req` only when it retires a second time in a row at the same PC with the same word. The first retirement leaves both flags low.
- R4: A 32-bit branch with opcode 1100011 and bits 31:25 and 11:7 all zero counts as a spin only when `ret_taken` is high. A not-taken retirement of it leaves the flags low, or clears them if they were set.
- R5: When `ret_is_rvc` is high, only bits 15:0 are decoded. The value 0xA001 behaves as in R2. A word with bits 1:0 = 01, bits 15:13 = 110 or 111 and bits 12:10 and 6:2 all zero behaves as in R4.
- R6: With `wdog_en` high, each spin-detecting retirement raises `trap_req` in exactly the following cycle and clears `idle_loop` and `gate_req` instead of setting them.
- R7: `nop_hint` is high in the cycle after a 32-bit retirement whose opcode is 0110011, 0010011, 0110111 or 0010111 and whose bits 11:7 are zero. It is low after loads (opcode 0000011) with that field zero, after a nonzero field, and in cycles with no retirement.
- R8: Once set, `idle_loop` and `gate_req` stay high through cycles with no retirement while `irq_pend` is low.
- R9: When `irq_pend` is high, `idle_loop` and `gate_req` are low in the next cycle. This is so even if a spin retires in the same cycle.
- R10: A retirement that is not itself a detected spin, such as a new PC or a different word, clears `idle_loop` and `gate_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | PC_W | Address of the retiring instruction |
| ret_insn | input | 32 | Instruction word; bits 15:0 only when compressed |
| ret_is_rvc | input | 1 | Retiring instruction is a 16-bit encoding |
| ret_taken | input | 1 | Retiring conditional branch was taken |
| wdog_en | input | 1 | Trap on a detected spin instead of gating |
| irq_pend | input | 1 | An interrupt is pending |
| nop_hint | output | 1 | Previous retirement was an effective no-op |
| idle_loop | output | 1 | Core is spinning on a proven idle loop |
| gate_req | output | 1 | Request to gate the execute-stage clock |
| trap_req | output | 1 | Single-cycle trap request on a watched spin |

## Verification
All four outputs come from flops that load on the rising edge that samples the retirement. Each result is therefore due exactly one cycle after its stimulus. The one exception is the repeat rule for linking jumps, which needs two back-to-back retirements, so its result is due one cycle after the second. The bench applies every input at a falling edge and reads the outputs at the next falling edge. This way each check lands half a period after the edge that produced the value, and the stimulus for the next step is already in place. Held states such as the sleep flag are also checked across several idle cycles.

// File: rtl/spin_idle_pkg.sv
package spin_idle_pkg;

   localparam int ILEN = 32;
   localparam int RVC_LEN = 16;

   typedef enum logic [1:0] {
      LOOP_NONE     = 2'd0,
      LOOP_JAL_X0   = 2'd1,
      LOOP_JAL_LINK = 2'd2,
      LOOP_BRANCH   = 2'd3
   } loop_kind_e;

   localparam logic [6:0] OPC_JAL    = 7'b1101111;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_OP     = 7'b0110011;
   localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_AUIPC  = 7'b0010111;

   localparam logic [RVC_LEN-1:0] RVC_J_SELF = 16'hA001;

endpackage

// File: rtl/spin_idle_decode.sv
module spin_idle_decode
   import spin_idle_pkg::*;
#(
   parameter bit ENABLE_RVC = 1'b1
) (
   input  logic [ILEN-1:0] insn,
   input  logic            is_rvc,
   output loop_kind_e      kind,
   output logic            x0_nop
);

   logic [6:0] opc;
   logic [4:0] rd_f;
   logic       opc_alu;
   loop_kind_e kind_w;
   loop_kind_e kind_c;

   assign opc  = insn[6:0];
   assign rd_f = insn[11:7];

   // full-width self-loop classification
   always_comb begin
      kind_w = LOOP_NONE;
      if (opc == OPC_JAL && insn[31:12] == 20'd0) begin
         kind_w = (rd_f == 5'd0) ? LOOP_JAL_X0 : LOOP_JAL_LINK;
      end else if (opc == OPC_BRANCH && insn[31:25] == 7'd0 && rd_f == 5'd0) begin
         kind_w = LOOP_BRANCH;
      end
   end

   // compressed variant chosen at elaboration
   generate
      if (ENABLE_RVC) begin : g_rvc
         always_comb begin
            kind_c = LOOP_NONE;
            if (insn[RVC_LEN-1:0] == RVC_J_SELF) begin
               kind_c = LOOP_JAL_X0;
            end else if (insn[1:0] == 2'b01 && insn[15:14] == 2'b11 &&
                         insn[12:10] == 3'd0 && insn[6:2] == 5'd0) begin
               kind_c = LOOP_BRANCH;
            end
         end
      end else begin : g_no_rvc
         assign kind_c = LOOP_NONE;
      end
   endgenerate

   assign kind = is_rvc ? kind_c : kind_w;

   always_comb begin
      case (opc)
         OPC_OP, OPC_OPIMM, OPC_LUI, OPC_AUIPC: opc_alu = 1'b1;
         default:                               opc_alu = 1'b0;
      endcase
   end

   assign x0_nop = !is_rvc && opc_alu && (rd_f == 5'd0);

endmodule

// File: rtl/spin_idle_repeat.sv
module spin_idle_repeat
   import spin_idle_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            valid,
   input  logic [PC_W-1:0] pc,
   input  logic [ILEN-1:0] insn,
   input  logic            is_rvc,
   output logic            same
);

   localparam int KEY_W = ILEN + 1;

   logic [KEY_W-1:0] key;
   logic [KEY_W-1:0] key_q;
   logic [PC_W-1:0]  pc_q;
   logic             have_q;

   // compressed words compare on their low half only
   assign key = is_rvc ? {1'b1, {(ILEN-RVC_LEN){1'b0}}, insn[RVC_LEN-1:0]}
                       : {1'b0, insn};

   always_ff @(posedge clk) begin
      if (rst) begin
         key_q  <= '0;
         pc_q   <= '0;
         have_q <= 1'b0;
      end else if (valid) begin
         key_q  <= key;
         pc_q   <= pc;
         have_q <= 1'b1;
      end
   end

   assign same = have_q && (pc == pc_q) && (key == key_q);

endmodule

// File: rtl/spin_idle_ctrl.sv
module spin_idle_ctrl
   import spin_idle_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       valid,
   input  loop_kind_e kind,
   input  logic       x0_nop,
   input  logic       same,
   input  logic       taken,
   input  logic       wdog_en,
   input  logic       irq_pend,
   output logic       nop_hint,
   output logic       idle_loop,
   output logic       gate_req,
   output logic       trap_req
);

   logic hit;
   logic idle_q;
   logic nop_q;
   logic trap_q;

   always_comb begin
      case (kind)
         LOOP_JAL_X0:   hit = valid;
         LOOP_JAL_LINK: hit = valid && same;
         LOOP_BRANCH:   hit = valid && taken;
         default:       hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         idle_q <= 1'b0;
         nop_q  <= 1'b0;
         trap_q <= 1'b0;
      end else begin
         nop_q  <= valid && x0_nop;
         trap_q <= hit && wdog_en;
         if (irq_pend) begin
            idle_q <= 1'b0;
         end else if (valid) begin
            idle_q <= hit && !wdog_en;
         end
      end
   end

   assign nop_hint  = nop_q;
   assign idle_loop = idle_q;
   assign gate_req  = idle_q;
   assign trap_req  = trap_q;

endmodule

// File: rtl/spin_idle_gate.sv
module spin_idle_gate
   import spin_idle_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter bit ENABLE_RVC = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ret_valid,
   input  logic [PC_W-1:0] ret_pc,
   input  logic [31:0]     ret_insn,
   input  logic            ret_is_rvc,
   input  logic            ret_taken,
   input  logic            wdog_en,
   input  logic            irq_pend,
   output logic            nop_hint,
   output logic            idle_loop,
   output logic            gate_req,
   output logic            trap_req
);

   generate
      if (PC_W < 16 || PC_W > 64) begin : g_bad_pc_w
         $error("spin_idle_gate: PC_W must lie in 16..64");
      end
   endgenerate

   loop_kind_e kind;
   logic       x0_nop;
   logic       same;

   spin_idle_decode #(.ENABLE_RVC(ENABLE_RVC)) u_decode (
      .insn   (ret_insn),
      .is_rvc (ret_is_rvc),
      .kind   (kind),
      .x0_nop (x0_nop)
   );

   spin_idle_repeat #(.PC_W(PC_W)) u_repeat (
      .clk    (clk),
      .rst    (rst),
      .valid  (ret_valid),
      .pc     (ret_pc),
      .insn   (ret_insn),
      .is_rvc (ret_is_rvc),
      .same   (same)
   );

   spin_idle_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .valid     (ret_valid),
      .kind      (kind),
      .x0_nop    (x0_nop),
      .same      (same),
      .taken     (ret_taken),
      .wdog_en   (wdog_en),
      .irq_pend  (irq_pend),
      .nop_hint  (nop_hint),
      .idle_loop (idle_loop),
      .gate_req  (gate_req),
      .trap_req  (trap_req)
   );

endmodule

// File: rtl/spin_idle_gate_chk.sv
module spin_idle_gate_chk (
   input logic clk,
   input logic rst,
   input logic ret_valid,
   input logic ret_is_rvc,
   input logic wdog_en,
   input logic irq_pend,
   input logic nop_hint,
   input logic idle_loop,
   input logic gate_req,
   input logic trap_req
);

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (!nop_hint && !idle_loop && !gate_req && !trap_req));

   a_r2_rise_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(idle_loop) |-> ($past(ret_valid) && !$past(wdog_en) && !$past(irq_pend)));

   a_r6_trap_cause: assert property (@(posedge clk) disable iff (rst)
      trap_req |-> ($past(ret_valid) && $past(wdog_en)));

   a_r6_trap_no_gate: assert property (@(posedge clk) disable iff (rst)
      trap_req |-> !gate_req);

   a_r7_hint_source: assert property (@(posedge clk) disable iff (rst)
      nop_hint |-> ($past(ret_valid) && !$past(ret_is_rvc)));

   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      (idle_loop && !ret_valid && !irq_pend) |=> idle_loop);

   a_r9_irq_release: assert property (@(posedge clk) disable iff (rst)
      irq_pend |=> (!idle_loop && !gate_req));

endmodule

bind spin_idle_gate spin_idle_gate_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .ret_valid  (ret_valid),
   .ret_is_rvc (ret_is_rvc),
   .wdog_en    (wdog_en),
   .irq_pend   (irq_pend),
   .nop_hint   (nop_hint),
   .idle_loop  (idle_loop),
   .gate_req   (gate_req),
   .trap_req   (trap_req)
);

// File: tb/spin_idle_gate_tb.sv
module spin_idle_gate_tb;

   typedef struct packed {
      logic        v;
      logic        c;
      logic        t;
      logic        w;
      logic        i;
      logic [31:0] pc;
      logic [31:0] ins;
      logic        nop;
      logic        idle;
      logic        gate;
      logic        trap;
      int          rq;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h100,32'h00000013,1'b1,1'b0,1'b0,1'b0,7}, // R7 addi x0
      '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h104,32'h00208033,1'b1,1'b0,1'b0,1'b0,7}, // R7 add x0
      '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h108,32'h00001037,1'b1,1'b0,1'b0,1'b0,7}, // R7 lui x0
      '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h10C,32'h00001017,1'b1,1'b0,1'b0,1'b0,7}, // R7 auipc x0
      '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h110,32'h0000A003,1'b0,1'b0,1'b0,1'b0,7}, // R7 load x0
      '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h114,32'h00100293,1'b0,1'b0,1'b0,1'b0,7}, // R7 rd!=0
      '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h000,32'h00000000,1'b0,1'b0,1'b0,1'b0,7}, // R7 no retire
      '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h200,32'h0000006F,1'b0,1'b1,1'b1,1'b0,2}, // R2
      '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h000,32'h00000000,1'b0,1'b1,1'b1,1'b0,8}, // R8
      '{1'b0,1'b0,1'b0,1'b0,1'b1,32'h000,32'h00000000,1'b0,1'b0,1'b0,1'b0,9}, // R9
      '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h300,32'h000000EF,1'b0,1'b0,1'b0,1'b0,3}, // R3 first
      '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h300,32'h000000EF,1'b0,1'b1,1'b1,1'b0,3}, // R3 repeat
      '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h304,32'h00100293,1'b0,1'b0,1'b0,1'b0,10},// R10
      '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h400,32'h00209063,1'b0,1'b0,1'b0,1'b0,4}, // R4 not taken
      '{1'b1,1'b0,1'b1,1'b0,1'b0,32'h400,32'h00209063,1'b0,1'b1,1'b1,1'b0,4}, // R4 taken
      '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h400,32'h00209063,1'b0,1'b0,1'b0,1'b0,4}, // R4 clears
      '{1'b1,1'b1,1'b0,1'b0,1'b0,32'h500,32'h0000A001,1'b0,1'b1,1'b1,1'b0,5}, // R5 c.j
      '{1'b0,1'b0,1'b0,1'b0,1'b1,32'h000,32'h00000000,1'b0,1'b0,1'b0,1'b0,9}, // R9
      '{1'b1,1'b1,1'b0,1'b0,1'b0,32'h600,32'h0000C001,1'b0,1'b0,1'b0,1'b0,5}, // R5 c.beqz nt
      '{1'b1,1'b1,1'b1,1'b0,1'b0,32'h602,32'h0000E001,1'b0,1'b1,1'b1,1'b0,5}, // R5 c.bnez t
      '{1'b1,1'b0,1'b0,1'b1,1'b0,32'h200,32'h0000006F,1'b0,1'b0,1'b0,1'b1,6}, // R6 trap
      '{1'b0,1'b0,1'b0,1'b1,1'b0,32'h000,32'h00000000,1'b0,1'b0,1'b0,1'b0,6}, // R6 one cycle
      '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h200,32'h0000006F,1'b0,1'b1,1'b1,1'b0,2}, // R2
      '{1'b1,1'b0,1'b0,1'b0,1'b1,32'h200,32'h0000006F,1'b0,1'b0,1'b0,1'b0,9}, // R9 priority
      '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h700,32'h0000006F,1'b0,1'b1,1'b1,1'b0,2}, // R2
      '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h700,32'h000000EF,1'b0,1'b0,1'b0,1'b0,10} // R10
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        ret_valid;
   logic [31:0] ret_pc;
   logic [31:0] ret_insn;
   logic        ret_is_rvc;
   logic        ret_taken;
   logic        wdog_en;
   logic        irq_pend;
   logic        nop_hint;
   logic        idle_loop;
   logic        gate_req;
   logic        trap_req;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   spin_idle_gate u_dut (
      .clk        (clk),
      .rst        (rst),
      .ret_valid  (ret_valid),
      .ret_pc     (ret_pc),
      .ret_insn   (ret_insn),
      .ret_is_rvc (ret_is_rvc),
      .ret_taken  (ret_taken),
      .wdog_en    (wdog_en),
      .irq_pend   (irq_pend),
      .nop_hint   (nop_hint),
      .idle_loop  (idle_loop),
      .gate_req   (gate_req),
      .trap_req   (trap_req)
   );

   task automatic drive(input logic v, input logic c, input logic t, input logic w,
                        input logic i, input logic [31:0] pc, input logic [31:0] ins);
      ret_valid  = v;
      ret_is_rvc = c;
      ret_taken  = t;
      wdog_en    = w;
      irq_pend   = i;
      ret_pc     = pc;
      ret_insn   = ins;
   endtask

   task automatic check(input string req, input logic [3:0] exp);
      logic [3:0] act;
      act = {nop_hint, idle_loop, gate_req, trap_req};
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s {nop,idle,gate,trap} actual=%b expected=%b", req, act, exp);
      end
   endtask

   // apply at a falling edge, result due at the next falling edge
   task automatic step(input logic v, input logic c, input logic t, input logic w,
                       input logic i, input logic [31:0] pc, input logic [31:0] ins);
      drive(v, c, t, w, i, pc, ins);
      @(negedge clk);
   endtask

   initial begin
      rst = 1'b1;
      drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
      repeat (3) @(negedge clk);
      check("R1 reset state", 4'b0000);
      rst = 1'b0;

      for (int k = 0; k < NV; k++) begin
         step(VECS[k].v, VECS[k].c, VECS[k].t, VECS[k].w, VECS[k].i,
              VECS[k].pc, VECS[k].ins);
         check($sformatf("R%0d vector %0d", VECS[k].rq, k),
               {VECS[k].nop, VECS[k].idle, VECS[k].gate, VECS[k].trap});
      end

      // R1: reset while sleeping drops everything
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h200, 32'h0000006F);
      check("R2 set before reset", 4'b0110);
      rst = 1'b1;
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
      check("R1 reset while idle", 4'b0000);
      rst = 1'b0;

      // R1: stored compare state is forgotten across reset
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h300, 32'h000000EF);
      check("R3 link first", 4'b0000);
      rst = 1'b1;
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
      rst = 1'b0;
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h300, 32'h000000EF);
      check("R1 no repeat across reset", 4'b0000);
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h300, 32'h000000EF);
      check("R3 repeat after reset", 4'b0110);

      // R8: hold through quiet cycles
      for (int q = 0; q < 5; q++) begin
         step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
         check("R8 hold while quiet", 4'b0110);
      end
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0);
      check("R9 release", 4'b0000);

      // R5: upper half of a compressed word is ignored
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h800, 32'hFFFFA001);
      check("R5 upper bits ignored", 4'b0110);

      // R4 and R6: taken branch under watchdog traps
      step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h900, 32'h00000063);
      check("R6 branch trap", 4'b0001);
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h900, 32'h00000063);
      check("R4 not taken no trap", 4'b0000);

      // R7: compressed word is never hinted
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'hA00, 32'h00000001);
      check("R7 compressed not hinted", 4'b0000);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule